// File: doc/BRIEF.md
# FIFO Threshold Interrupt Aggregator

This block builds the interrupt vector and the DMA request for a two-wire serial bus controller with four FIFOs: command/format, receive, acquire and transmit. It compares each FIFO fill level with a programmable low or high threshold. It takes single-cycle event pulses from the bus engines, a controller-event register value and a receive-write strobe. From these it keeps one state bit per interrupt.

There are two kinds of interrupt. Status interrupts mirror a live condition every cycle, and software cannot clear them. Event interrupts are sticky: a pulse sets the bit, and it stays set until software writes 1 to clear it. A small register-write port selects one of three targets: the state bits (write-1-to-clear), the enable mask, or a test register that forces state bits high. Each interrupt line is its state bit gated by its enable bit.

A separate DMA trigger fires for one cycle when the receive-above-high or transmit-below-low watermark condition rises.

Top module: `fifo_irq_aggregator`

## Requirements
- R1: Bit 0 of `irq_o` (format low) is set one clock after the format level is strictly below `fmt_lo_i`, and clear one clock after it is not.
- R2: Bit 1 (receive high) tracks receive level strictly above `rx_hi_i`. Bit 2 (acquire high) tracks acquire level strictly above `acq_hi_i`. Both have one clock of latency.
- R3: Bit 3 (transmit low) tracks transmit level strictly below `tx_lo_i`, with one clock of latency.
- R4: Bit 4 follows `tx_stretch_i` and bit 5 follows `acq_stretch_i`, each one clock later.
- R5: Bit 6 (controller halt) is set while any bit of `ctrl_evt_i` is 1 and drops one clock after all bits are 0.
- R6: Bit 7 (receive overflow) is set when `rx_wr_i` is high while the receive level equals `RX_DEPTH`. A write below full does not set it.
- R7: Bits 8 to 14 are event bits set by `ev_pulse_i[0]` to `ev_pulse_i[6]` in that order. They stay set after the pulse ends, until a state write (`reg_sel_i`=0) has a 1 in that bit.
- R8: If an event pulse and a clearing write for the same bit land in the same cycle, the bit ends up set.
- R9: State writes to bits 0 to 6 (status kind) have no effect. Those bits keep following their live conditions.
- R10: `irq_o` is state AND enable. The enable mask is written with `reg_sel_i`=1.
- R11: A write with `reg_sel_i`=2 forces the written state bits high for the next cycle. A status bit then falls back to its live value, while an event bit stays latched.
- R12: `dma_trig_o` is a one-cycle pulse, one clock after the condition (receive above high OR transmit below low) goes from 0 to 1. It does not repeat while the condition holds, and it ignores the enable mask.
- R13: Under reset all state bits, enables and `dma_trig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_lvl_i | input | LVL_W | Format FIFO level |
| rx_lvl_i | input | LVL_W | Receive FIFO level |
| acq_lvl_i | input | LVL_W | Acquire FIFO level |
| tx_lvl_i | input | LVL_W | Transmit FIFO level |
| fmt_lo_i | input | LVL_W | Format low threshold |
| rx_hi_i | input | LVL_W | Receive high threshold |
| acq_hi_i | input | LVL_W | Acquire high threshold |
| tx_lo_i | input | LVL_W | Transmit low threshold |
| tx_stretch_i | input | 1 | Target stretching for read data |
| acq_stretch_i | input | 1 | Target stretching for acquire space |
| ctrl_evt_i | input | CEV_W | Controller-event register value |
| rx_wr_i | input | 1 | Receive FIFO write attempt |
| ev_pulse_i | input | 7 | Event pulses for interrupt bits 8..14 |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Target: 0 state, 1 enable, 2 test |
| reg_wdata_i | input | 15 | Write data |
| irq_o | output | 15 | Gated interrupt vector |
| dma_trig_o | output | 1 | Single-cycle DMA trigger |

## Verification
The bench probes levels exactly equal to each threshold. A design that used a non-strict compare would raise an interrupt there. It sends an event pulse in the same cycle as a clearing write, which catches a design where the clear wins. It tries to clear live status bits, which catches logic that treats every bit as write-1-to-clear. It holds the watermark condition high over several cycles with the enable mask at zero, which exposes a trigger that repeats or that is gated by the enables. Test writes are checked one and two cycles later, so a test bit that never falls, or an event bit that fails to latch, is caught.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int NUM_IRQ = 15;
    localparam int NUM_EVT = 7;

    // interrupt bit positions
    localparam int IRQ_FMT_LOW     = 0;
    localparam int IRQ_RX_HIGH     = 1;
    localparam int IRQ_ACQ_HIGH    = 2;
    localparam int IRQ_TX_LOW      = 3;
    localparam int IRQ_TX_STRETCH  = 4;
    localparam int IRQ_ACQ_STRETCH = 5;
    localparam int IRQ_HALT        = 6;
    localparam int IRQ_RX_OVF      = 7;
    localparam int IRQ_EVT_BASE    = 8;

    // 1 marks a status-kind bit
    localparam logic [NUM_IRQ-1:0] STATUS_MASK = 15'h007F;

    typedef enum logic [1:0] {
        SEL_STATE  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_TEST   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic                we;
        reg_sel_e            sel;
        logic [NUM_IRQ-1:0]  data;
    } reg_wr_t;

endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
    parameter int LVL_W = 6,
    parameter bit ABOVE = 1'b1
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] thr,
    output logic             hit
);
    generate
        if (ABOVE) begin : g_above
            assign hit = (lvl > thr);
        end else begin : g_below
            assign hit = (lvl < thr);
        end
    endgenerate
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import fifo_irq_pkg::*;
#(
    parameter int                N     = NUM_IRQ,
    parameter logic [N-1:0]      SMASK = STATUS_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  hw_set,
    input  reg_wr_t       wr,
    output logic [N-1:0]  state_o,
    output logic [N-1:0]  en_o
);
    logic [N-1:0] clr_hit;
    logic [N-1:0] test_hit;
    logic [N-1:0] en_q;

    assign clr_hit  = (wr.we && wr.sel == SEL_STATE) ? wr.data : '0;
    assign test_hit = (wr.we && wr.sel == SEL_TEST)  ? wr.data : '0;

    always_ff @(posedge clk) begin
        if (rst)                               en_q <= '0;
        else if (wr.we && wr.sel == SEL_ENABLE) en_q <= wr.data;
    end
    assign en_o = en_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic bit_q;
            assign state_o[i] = bit_q;
            if (SMASK[i]) begin : g_status
                always_ff @(posedge clk) begin
                    if (rst) bit_q <= 1'b0;
                    else     bit_q <= hw_set[i] | test_hit[i];
                end
                // R9: software clear cannot drop a live status bit
                a_r9_status_live: assert property (@(posedge clk) disable iff (rst)
                    hw_set[i] |=> bit_q);
            end else begin : g_event
                always_ff @(posedge clk) begin
                    if (rst) bit_q <= 1'b0;
                    else     bit_q <= (bit_q & ~clr_hit[i]) | hw_set[i] | test_hit[i];
                end
                a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
                    hw_set[i] |=> bit_q);
                a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
                    (bit_q && !clr_hit[i]) |=> bit_q);
            end
        end
    endgenerate
endmodule

// File: rtl/dma_edge_pulse.sv
module dma_edge_pulse (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic pulse_o
);
    logic cond_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cond_q  <= cond;
            pulse_q <= cond & ~cond_q;
        end
    end
    assign pulse_o = pulse_q;

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/fifo_irq_aggregator.sv
module fifo_irq_aggregator
    import fifo_irq_pkg::*;
#(
    parameter int LVL_W    = 6,
    parameter int RX_DEPTH = 32,
    parameter int CEV_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LVL_W-1:0]     fmt_lvl_i,
    input  logic [LVL_W-1:0]     rx_lvl_i,
    input  logic [LVL_W-1:0]     acq_lvl_i,
    input  logic [LVL_W-1:0]     tx_lvl_i,
    input  logic [LVL_W-1:0]     fmt_lo_i,
    input  logic [LVL_W-1:0]     rx_hi_i,
    input  logic [LVL_W-1:0]     acq_hi_i,
    input  logic [LVL_W-1:0]     tx_lo_i,
    input  logic                 tx_stretch_i,
    input  logic                 acq_stretch_i,
    input  logic [CEV_W-1:0]     ctrl_evt_i,
    input  logic                 rx_wr_i,
    input  logic [NUM_EVT-1:0]   ev_pulse_i,
    input  logic                 reg_we_i,
    input  logic [1:0]           reg_sel_i,
    input  logic [NUM_IRQ-1:0]   reg_wdata_i,
    output logic [NUM_IRQ-1:0]   irq_o,
    output logic                 dma_trig_o
);
    localparam logic [LVL_W-1:0] RX_FULL_LVL = LVL_W'(RX_DEPTH);

    logic fmt_low, rx_high, acq_high, tx_low;
    logic rx_ovf;
    logic [NUM_IRQ-1:0] hw_set;
    logic [NUM_IRQ-1:0] irq_state;
    logic [NUM_IRQ-1:0] irq_en;
    reg_wr_t wr;

    irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b0)) u_fmt (.lvl(fmt_lvl_i), .thr(fmt_lo_i), .hit(fmt_low));
    irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b1)) u_rx  (.lvl(rx_lvl_i),  .thr(rx_hi_i),  .hit(rx_high));
    irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b1)) u_acq (.lvl(acq_lvl_i), .thr(acq_hi_i), .hit(acq_high));
    irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b0)) u_tx  (.lvl(tx_lvl_i),  .thr(tx_lo_i),  .hit(tx_low));

    assign rx_ovf = rx_wr_i && (rx_lvl_i == RX_FULL_LVL);

    always_comb begin
        hw_set                  = '0;
        hw_set[IRQ_FMT_LOW]     = fmt_low;
        hw_set[IRQ_RX_HIGH]     = rx_high;
        hw_set[IRQ_ACQ_HIGH]    = acq_high;
        hw_set[IRQ_TX_LOW]      = tx_low;
        hw_set[IRQ_TX_STRETCH]  = tx_stretch_i;
        hw_set[IRQ_ACQ_STRETCH] = acq_stretch_i;
        hw_set[IRQ_HALT]        = |ctrl_evt_i;
        hw_set[IRQ_RX_OVF]      = rx_ovf;
        hw_set[IRQ_EVT_BASE +: NUM_EVT] = ev_pulse_i;
    end

    assign wr.we   = reg_we_i;
    assign wr.sel  = reg_sel_e'(reg_sel_i);
    assign wr.data = reg_wdata_i;

    irq_state_bank #(.N(NUM_IRQ), .SMASK(STATUS_MASK)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .hw_set  (hw_set),
        .wr      (wr),
        .state_o (irq_state),
        .en_o    (irq_en)
    );

    assign irq_o = irq_state & irq_en;

    dma_edge_pulse u_dma (
        .clk     (clk),
        .rst     (rst),
        .cond    (rx_high | tx_low),
        .pulse_o (dma_trig_o)
    );

    a_r5_halt_track: assert property (@(posedge clk) disable iff (rst)
        (|ctrl_evt_i) |=> irq_state[IRQ_HALT]);
    a_r6_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (rx_wr_i && rx_lvl_i == RX_FULL_LVL) |=> irq_state[IRQ_RX_OVF]);
    a_r10_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~irq_en) == '0);
endmodule

// File: tb/tb_fifo_irq_aggregator.sv
module tb_fifo_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 6;
    localparam int CEV_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LVL_W-1:0] fmt_lvl, rx_lvl, acq_lvl, tx_lvl;
    logic [LVL_W-1:0] fmt_lo, rx_hi, acq_hi, tx_lo;
    logic tx_st, acq_st, rx_wr, we;
    logic [CEV_W-1:0] cev;
    logic [6:0] evp;
    logic [1:0] sel;
    logic [14:0] wdata, irq;
    logic dma;

    int n_chk = 0;
    int n_bad = 0;
    bit prev_cond = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_irq_aggregator dut (
        .clk(clk), .rst(rst),
        .fmt_lvl_i(fmt_lvl), .rx_lvl_i(rx_lvl), .acq_lvl_i(acq_lvl), .tx_lvl_i(tx_lvl),
        .fmt_lo_i(fmt_lo), .rx_hi_i(rx_hi), .acq_hi_i(acq_hi), .tx_lo_i(tx_lo),
        .tx_stretch_i(tx_st), .acq_stretch_i(acq_st), .ctrl_evt_i(cev),
        .rx_wr_i(rx_wr), .ev_pulse_i(evp),
        .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
        .irq_o(irq), .dma_trig_o(dma)
    );

    // fields: fmt[27:22] rx[21:16] acq[15:10] tx[9:4] expected bits3..0
    // thresholds: fmt_lo=4 rx_hi=10 acq_hi=12 tx_lo=3
    localparam logic [27:0] VEC [8] = '{
        {6'd5,  6'd0,  6'd0,  6'd5,  4'b0000},
        {6'd3,  6'd0,  6'd0,  6'd5,  4'b0001},
        {6'd4,  6'd10, 6'd12, 6'd3,  4'b0000},
        {6'd4,  6'd11, 6'd13, 6'd3,  4'b0110},
        {6'd10, 6'd11, 6'd0,  6'd2,  4'b1010},
        {6'd0,  6'd32, 6'd32, 6'd0,  4'b1111},
        {6'd20, 6'd5,  6'd5,  6'd20, 4'b0000},
        {6'd4,  6'd10, 6'd13, 6'd2,  4'b1100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [14:0] d);
        we = 1'b1; sel = s; wdata = d;
        step();
        we = 1'b0; wdata = '0;
    endtask

    task automatic quiet();
        fmt_lvl = 6'd5; rx_lvl = 6'd0; acq_lvl = 6'd0; tx_lvl = 6'd5;
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        quiet();
        fmt_lo = 6'd4; rx_hi = 6'd10; acq_hi = 6'd12; tx_lo = 6'd3;
        tx_st = 0; acq_st = 0; rx_wr = 0; cev = '0; evp = '0;
        we = 0; sel = 2'd0; wdata = '0;
        @(negedge clk);
        step(); step();
        // R13 reset values
        chk("R13 irq", irq, 0);
        chk("R13 dma", dma, 0);
        rst = 1'b0;
        step();
        wr(2'd1, 15'h7FFF);
        chk("R13 state after reset", irq, 0);

        // table walk: R1 R2 R3 and R12
        for (int k = 0; k < 8; k++) begin
            logic [27:0] v;
            bit cond;
            v = VEC[k];
            fmt_lvl = v[27:22]; rx_lvl = v[21:16]; acq_lvl = v[15:10]; tx_lvl = v[9:4];
            cond = v[1] | v[3];
            step();
            chk("R1 fmt low", irq[0], v[0]);
            chk("R2 rx/acq high", irq[2:1], v[2:1]);
            chk("R3 tx low", irq[3], v[3]);
            chk("R12 dma edge", dma, cond & ~prev_cond);
            prev_cond = cond;
        end
        quiet();
        step();

        // R4 stretch status
        tx_st = 1; step();
        chk("R4 tx stretch", irq[5:4], 2'b01);
        tx_st = 0; acq_st = 1; step();
        chk("R4 acq stretch", irq[5:4], 2'b10);
        // R9: clearing a live status bit is ignored
        wr(2'd0, 15'h007F);
        chk("R9 status not cleared", irq[5], 1);
        acq_st = 0; step();
        chk("R4 stretch release", irq[5:4], 0);

        // R5 halt
        cev = 4'b0100; step();
        chk("R5 halt set", irq[6], 1);
        step();
        chk("R5 halt held", irq[6], 1);
        cev = '0; step();
        chk("R5 halt released", irq[6], 0);

        // R6 overflow
        rx_lvl = 6'd31; rx_wr = 1; step(); rx_wr = 0;
        chk("R6 no ovf below full", irq[7], 0);
        rx_lvl = 6'd32; rx_wr = 1; step(); rx_wr = 0; rx_lvl = 6'd0;
        chk("R6 ovf on full", irq[7], 1);
        wr(2'd0, 15'h0080);
        chk("R6 ovf cleared", irq[7], 0);

        // R7 sticky events, bit 8+j from ev_pulse_i[j]
        evp = 7'b0000001; step(); evp = '0;
        chk("R7 evt set", irq[14:8], 7'b0000001);
        step(); step();
        chk("R7 evt sticky", irq[14:8], 7'b0000001);
        evp = 7'b1000000; step(); evp = '0;
        chk("R7 evt top bit", irq[14:8], 7'b1000001);
        wr(2'd0, 15'h0100);
        chk("R7 w1c one bit", irq[14:8], 7'b1000000);

        // R8 set wins over clear
        evp = 7'b1000000; we = 1; sel = 2'd0; wdata = 15'h4000;
        step();
        evp = '0; we = 0; wdata = '0;
        chk("R8 set wins", irq[14], 1);
        wr(2'd0, 15'h4000);
        chk("R8 later clear", irq[14], 0);

        // R10 enable gating
        evp = 7'b0010000; step(); evp = '0;
        wr(2'd1, 15'h0000);
        chk("R10 masked", irq, 0);
        wr(2'd1, 15'h1000);
        chk("R10 unmasked", irq, 15'h1000);
        wr(2'd0, 15'h1000);
        wr(2'd1, 15'h7FFF);

        // R11 test register
        wr(2'd2, 15'h0801);
        chk("R11 forced", irq, 15'h0801);
        step();
        chk("R11 status falls, event stays", irq, 15'h0800);
        wr(2'd0, 15'h0800);
        chk("R11 cleared", irq, 0);

        // R12 dma ignores enable, no repeat while held
        wr(2'd1, 15'h0000);
        rx_lvl = 6'd11; step();
        chk("R12 dma pulse", dma, 1);
        step();
        chk("R12 dma self clear", dma, 0);
        tx_lvl = 6'd1; step();
        chk("R12 no repeat while held", dma, 0);
        quiet(); step();
        tx_lvl = 6'd0; step();
        chk("R12 second rise", dma, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule